// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration image into a target FPGA over a slave-serial link. It owns three outputs toward the target: an active-low program request, a configuration clock and a serial data line. It watches two status inputs from the target: init-ready and done. Both pass through a two-flop synchronizer before the sequencer uses them. The image reaches the block as a byte stream with a valid/ready handshake. The total length in bytes is given at start.

A one-cycle start pulse begins a load. The sequencer first holds the program request low for a set number of system clocks, then releases it. It polls init-ready for a bounded number of cycles. Next it shifts every image byte out MSB first. Finally it keeps pulsing the configuration clock until done rises or a pulse limit runs out.

An optional swap mode sends the bytes of each 4-byte word in reverse order, so stream index i goes out in position i XOR 3. The block reports the result on separate success and error outputs, which hold until the next start.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, and whenever the block is not busy, prog_n is high, cclk and din are low, and in_ready is low. busy, ok and err are low after reset.
- R2: An accepted start drives prog_n low for exactly PROG_CYC system-clock cycles and then returns it high.
- R3: If synchronized init_rdy is not seen high within INIT_MAX polls after prog_n is released, err is raised. In that case no byte is accepted, no cclk pulse is produced, and busy is high for exactly PROG_CYC+INIT_MAX cycles.
- R4: Each cclk high phase lasts CLK_DIV system cycles. din changes only while cclk is low, and in_ready is only high while cclk is low.
- R5: With swap_en low, the bits the target samples on the rising edges of cclk are the image bytes in stream order, each MSB first.
- R6: With swap_en high, the bytes go out in the order 3,2,1,0,7,6,5,4,… (stream index XOR 3).
- R7: A start with swap_en high and img_len[1:0] not zero raises err on the next cycle. It produces no program pulse, busy stays low, and no byte is accepted.
- R8: After the last data bit, cclk keeps pulsing until synchronized done_in is high. The block then raises ok and clears busy.
- R9: If done_in never rises, the block raises err after exactly DONE_MAX extra cclk pulses, so the total is 8*img_len + DONE_MAX rising edges.
- R10: A start pulse while busy is ignored: no second program pulse appears, and the byte stream is unaffected.
- R11: ok and err are never high together. One of them is set when busy falls. Both hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (one-cycle pulse) |
| swap_en | input | 1 | Reverse byte order inside each 4-byte word |
| img_len | input | LEN_W | Image length in bytes, sampled at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| prog_n | output | 1 | Program request to target, active low |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Serial configuration data |
| init_rdy | input | 1 | Target ready for data (asynchronous) |
| done_in | input | 1 | Target configuration done (asynchronous) |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |

## Verification
The target is modelled so that the bench can rebuild bytes from din on each rising cclk edge and compare them against a queue of expected bytes. Swapped words are also checked this way: a design that rebuilt words in the wrong order would show reordered bytes. A swap load whose length is not a multiple of four must fail at once. A design that started anyway would show a program pulse and accepted bytes.

Both timeouts are checked for exact length. An off-by-one poll or pulse counter shows up as a wrong busy duration, or as a wrong total number of cclk edges. A start issued during a load must not cause a second program pulse. Stale error flags must clear on the next start.

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader #(
  parameter int CLK_DIV  = 4,
  parameter int PROG_CYC = 12_500_000,
  parameter int INIT_MAX = 100_000,
  parameter int DONE_MAX = 100_000,
  parameter int LEN_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             swap_en,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             prog_n,
  output logic             cclk,
  output logic             din,
  input  logic             init_rdy,
  input  logic             done_in,
  output logic             busy,
  output logic             ok,
  output logic             err
);
  localparam int MAXA = PROG_CYC > INIT_MAX ? PROG_CYC : INIT_MAX;
  localparam int MAXC = MAXA > DONE_MAX ? MAXA : DONE_MAX;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int HW   = $clog2(CLK_DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_INIT, S_FETCH, S_SHIFT, S_FLUSH} st_t;
  st_t st;

  logic [1:0]       init_sy, done_sy;
  logic [TW-1:0]    tcnt;
  logic [HW-1:0]    hcnt;
  logic [LEN_W-1:0] left;
  logic [31:0]      wbuf;
  logic [1:0]       wcnt, pend;
  logic [2:0]       bitn;
  logic [7:0]       sreg;
  logic             swap_r;

  wire half_end = (hcnt == HW'(CLK_DIV - 1));
  assign busy     = (st != S_IDLE);
  assign in_ready = (st == S_FETCH);
  assign din      = sreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; prog_n <= 1'b1; cclk <= 1'b0; sreg <= '0;
      ok <= 1'b0; err <= 1'b0; init_sy <= '0; done_sy <= '0;
      tcnt <= '0; hcnt <= '0; left <= '0; wbuf <= '0;
      wcnt <= '0; pend <= '0; bitn <= '0; swap_r <= 1'b0;
    end else begin
      init_sy <= {init_sy[0], init_rdy};
      done_sy <= {done_sy[0], done_in};
      case (st)
        S_IDLE: if (start) begin
          ok <= 1'b0; err <= 1'b0; swap_r <= swap_en; left <= img_len;
          tcnt <= '0; hcnt <= '0; wcnt <= '0; pend <= '0; bitn <= '0;
          if (swap_en && img_len[1:0] != 2'b00) err <= 1'b1;
          else begin prog_n <= 1'b0; st <= S_PROG; end
        end
        S_PROG: if (tcnt == TW'(PROG_CYC - 1)) begin
          prog_n <= 1'b1; tcnt <= '0; st <= S_INIT;
        end else tcnt <= tcnt + 1'b1;
        S_INIT: if (init_sy[1]) begin
          tcnt <= '0; hcnt <= '0;
          st <= (left == '0) ? S_FLUSH : S_FETCH;
        end else if (tcnt == TW'(INIT_MAX - 1)) begin
          err <= 1'b1; st <= S_IDLE;
        end else tcnt <= tcnt + 1'b1;
        S_FETCH: if (in_valid) begin
          left <= left - 1'b1; hcnt <= '0; bitn <= '0;
          if (!swap_r) begin
            sreg <= in_data; st <= S_SHIFT;
          end else begin
            wbuf <= {in_data, wbuf[31:8]};
            wcnt <= wcnt + 1'b1;
            if (wcnt == 2'd3) begin sreg <= in_data; pend <= 2'd3; st <= S_SHIFT; end
          end
        end
        S_SHIFT: if (half_end) begin
          hcnt <= '0;
          if (!cclk) cclk <= 1'b1;
          else begin
            cclk <= 1'b0;
            sreg <= {sreg[6:0], 1'b0};
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              if (pend != 2'd0) begin
                sreg <= wbuf[23:16]; wbuf <= wbuf << 8; pend <= pend - 1'b1;
              end else if (left == '0) begin
                tcnt <= '0; st <= S_FLUSH;
              end else st <= S_FETCH;
            end
          end
        end else hcnt <= hcnt + 1'b1;
        S_FLUSH: if (half_end) begin
          hcnt <= '0;
          if (cclk) cclk <= 1'b0;
          else if (done_sy[1]) begin ok <= 1'b1; st <= S_IDLE; end
          else if (tcnt == TW'(DONE_MAX)) begin err <= 1'b1; st <= S_IDLE; end
          else begin cclk <= 1'b1; tcnt <= tcnt + 1'b1; end
        end else hcnt <= hcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module fpga_cfg_loader_chk #(parameter int LEN_W = 24) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             swap_en,
  input logic [LEN_W-1:0] img_len,
  input logic             in_ready,
  input logic             prog_n,
  input logic             cclk,
  input logic             din,
  input logic             busy,
  input logic             ok,
  input logic             err
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && !cclk && !din && !in_ready)); // R1
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (!cclk && !in_ready && busy)); // R2
  AST_DIN_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din)); // R4
  AST_READY_CCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cclk); // R4
  AST_SWAP_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && swap_en && img_len[1:0] != 2'b00) |=> (err && !busy)); // R7
  AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err)); // R11
  AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ok || err)); // R11
endmodule

bind fpga_cfg_loader fpga_cfg_loader_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .swap_en(swap_en), .img_len(img_len),
  .in_ready(in_ready), .prog_n(prog_n), .cclk(cclk), .din(din),
  .busy(busy), .ok(ok), .err(err));

// File: tb/fpga_cfg_loader_test.sv
module fpga_cfg_loader_test;
  localparam int CD = 2, PC = 20, IM = 40, DM = 30, LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, swap_en = 0, in_valid = 0;
  logic [LW-1:0] img_len = '0;
  logic [7:0] in_data = '0;
  logic in_ready, prog_n, cclk, din, busy, ok, err;
  logic init_en = 1'b1, done_en = 1'b1;
  int rises = 0, need = 0;
  logic init_rdy, done_in;
  assign init_rdy = init_en & prog_n;
  assign done_in  = done_en && (rises >= need);

  fpga_cfg_loader #(.CLK_DIV(CD), .PROG_CYC(PC), .INIT_MAX(IM), .DONE_MAX(DM), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .swap_en(swap_en), .img_len(img_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .prog_n(prog_n),
    .cclk(cclk), .din(din), .init_rdy(init_rdy), .done_in(done_in),
    .busy(busy), .ok(ok), .err(err));

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R5";
  logic [7:0] exp_q[$];
  int bits_left = 0, rx_n = 0, acc_cnt = 0;
  logic [7:0] rx = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target model + scoreboard monitor
  always @(posedge cclk) begin
    rises++;
    if (bits_left > 0) begin
      rx = {rx[6:0], din};
      bits_left--;
      rx_n++;
      if (rx_n == 8) begin
        rx_n = 0;
        if (exp_q.size() == 0) chk({cur_tag, " unexpected byte"}, rx, -1);
        else chk({cur_tag, " byte"}, rx, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) if (in_valid && in_ready) acc_cnt++;

  int busy_cyc = 0, plow = 0, plast = 0, pulses = 0, hcyc = 0, hw_bad = 0;
  logic pprev = 1'b1;
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (!prog_n) plow++;
    else if (!pprev) begin plast = plow; pulses++; plow = 0; end
    pprev = prog_n;
    if (cclk) hcyc++;
    else if (hcyc != 0) begin if (hcyc != CD) hw_bad++; hcyc = 0; end
  end

  task automatic clear_stats();
    rises = 0; acc_cnt = 0; busy_cyc = 0; pulses = 0; hw_bad = 0; rx_n = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + 37 * i) & 8'hFF);
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: pushes expected bytes and feeds the stream
  task automatic run_load(input int len, input bit sw, input int seed, input bit mid);
    clear_stats();
    img_len = LW'(len); swap_en = sw;
    bits_left = 8 * len; need = 8 * len + 3;
    for (int i = 0; i < len; i++) exp_q.push_back(pat(seed, sw ? (i ^ 3) : i));
    pulse_start();
    fork
      for (int i = 0; i < len; i++) begin
        in_valid = 1'b1; in_data = pat(seed, i);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
      if (mid) begin repeat (60) @(negedge clk); pulse_start(); end
    join
    in_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 prog_n", prog_n, 1); chk("R1 cclk", cclk, 0); chk("R1 din", din, 0);
    chk("R1 busy", busy, 0); chk("R1 ok", ok, 0); chk("R1 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready", in_ready, 0);

    cur_tag = "R5";
    run_load(5, 1'b0, 11, 1'b1);
    chk("R2 prog width", plast, PC);
    chk("R10 single prog pulse", pulses, 1);
    chk("R4 high width", hw_bad, 0);
    chk("R8 ok", ok, 1); chk("R8 err", err, 0);
    chk("R5 queue empty", exp_q.size(), 0);
    chk("R1 idle prog_n", prog_n, 1); chk("R1 idle cclk", cclk, 0);

    cur_tag = "R6";
    run_load(8, 1'b1, 200, 1'b0);
    chk("R6 queue empty", exp_q.size(), 0);
    chk("R6 ok", ok, 1);

    clear_stats();
    img_len = LW'(6); swap_en = 1'b1;
    pulse_start();
    chk("R7 err", err, 1); chk("R7 busy", busy, 0);
    repeat (PC + 5) @(negedge clk);
    chk("R7 no prog pulse", pulses, 0); chk("R7 no accept", acc_cnt, 0);
    chk("R11 ok low", ok, 0);

    clear_stats();
    init_en = 1'b0; img_len = LW'(4); swap_en = 1'b0;
    in_valid = 1'b1; in_data = 8'h5A;
    pulse_start();
    wait_idle();
    in_valid = 1'b0;
    chk("R3 err", err, 1); chk("R3 ok", ok, 0);
    chk("R3 no accept", acc_cnt, 0); chk("R3 no cclk", rises, 0);
    chk("R3 busy cycles", busy_cyc, PC + IM);
    init_en = 1'b1;

    cur_tag = "R9";
    done_en = 1'b0;
    run_load(2, 1'b0, 77, 1'b0);
    chk("R9 err", err, 1); chk("R9 ok", ok, 0);
    chk("R9 total cclk edges", rises, 16 + DM);
    done_en = 1'b1;

    cur_tag = "R5";
    clear_stats();
    img_len = LW'(3); swap_en = 1'b0; bits_left = 24; need = 27;
    for (int i = 0; i < 3; i++) exp_q.push_back(pat(5, i));
    pulse_start();
    chk("R11 err cleared", err, 0); chk("R11 busy", busy, 1);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = pat(5, i);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_idle();
    chk("R8 ok after recovery", ok, 1);
    chk("R5 queue empty", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule